// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register Block

This block holds the software-visible control and status state of a scatter-gather DMA dispatcher. Software reads and writes 32-bit words through a simple single-cycle register port. The block turns the control word into a stop request for descriptor dispatch and a soft-reset request that flushes the FIFOs. It collects completion events from the transfer engine and raises one interrupt line. The live state of the descriptor and response queues is reported back, together with their fill levels and sequence counters.

Completion events can set three sticky flags: a pending interrupt, a stop after an error, and a stop after early termination. Software clears each flag by writing a one to it. A soft reset runs for a fixed, parameterised number of cycles. During that time a resetting flag stays visible, the reset request output is held high, and the control word is forced to zero.

Top module: `dsp_csr`

## Requirements
- R1: After the asynchronous reset, the control word reads 0, the sticky status bits 9:7 read 0, and irq_o, stop_o and reset_o are 0.
- R2: The register index is addr_i[4:2]. Index 2 (byte 0x08) reads {wr_fill_i, rd_fill_i} in bits 31:16 and 15:0. Index 3 (byte 0x0C) reads resp_fill_i in bits 15:0 with zeros above. Index 4 (byte 0x10) reads {wr_seq_i, rd_seq_i} in bits 31:16 and 15:0. Indices 5 to 7 read 0. Writes to indices 2 to 7 change no state.
- R3: Status (index 0) bits 0 to 4 show eng_busy_i, dq_empty_i, dq_full_i, rq_empty_i and rq_full_i on every read. A status write has no effect on bits 0 to 6.
- R4: Control (index 1) stores bits 0 (stop), 2 (stop on error), 3 (stop on early end), 4 (interrupt enable) and 5 (stop descriptors), and reads them back. Bit 1 always reads 0. stop_o is high while bit 0 or bit 5 is set, or while status bit 7 or bit 8 is set.
- R5: A control write with bit 1 set starts a soft reset. For exactly RST_CYCLES cycles after the write edge, status bit 6 and reset_o are 1 and the control word reads 0. Control writes made during that time are ignored.
- R6: Status bit 9 is set by a completion (cmpl_valid_i) that has any of the following: cmpl_done_irq_i; a bit set in both cmpl_err_i and cmpl_err_irq_i; or both cmpl_early_i and cmpl_early_irq_i. A completion with none of these leaves bit 9 unchanged.
- R7: irq_o is status bit 9 AND control bit 4.
- R8: Writing 1 to status bit 7, 8 or 9 clears that bit. Writing 0 leaves it as it is. A set event in the same cycle wins over the clear.
- R9: While control bit 2 is set, a completion with a non-zero cmpl_err_i sets status bit 7. This holds stop_o high until software clears bit 7.
- R10: While control bit 3 is set, a completion with cmpl_early_i sets status bit 8. This holds stop_o high until software clears bit 8.
- R11: Status bit 5 (stopped) reads 1 when stop_o is high and eng_busy_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| eng_busy_i | input | 1 | Transfer engine busy |
| dq_empty_i | input | 1 | Descriptor queue empty |
| dq_full_i | input | 1 | Descriptor queue full |
| rq_empty_i | input | 1 | Response queue empty |
| rq_full_i | input | 1 | Response queue full |
| wr_fill_i | input | LVL_W | Write-side descriptor fill level |
| rd_fill_i | input | LVL_W | Read-side descriptor fill level |
| resp_fill_i | input | LVL_W | Response queue fill level |
| wr_seq_i | input | LVL_W | Write-side sequence number |
| rd_seq_i | input | LVL_W | Read-side sequence number |
| cmpl_valid_i | input | 1 | Descriptor completion event |
| cmpl_done_irq_i | input | 1 | The completion asked for an interrupt on finish |
| cmpl_err_i | input | ERR_W | Error bits of the completion |
| cmpl_err_irq_i | input | ERR_W | Per-error-bit interrupt requests |
| cmpl_early_i | input | 1 | The completion ended early |
| cmpl_early_irq_i | input | 1 | The completion asked for an interrupt on early end |
| stop_o | output | 1 | Halt descriptor dispatch |
| reset_o | output | 1 | Soft reset in progress, flush request |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with RST_CYCLES set to 5 and keeps the 16-bit level fields and 8-bit error vectors. The short reset makes it practical to count every cycle of the resetting window and to write to the control word inside that window. The 8-bit error vectors let the bench sweep every pairing of a single error bit with a single error-interrupt enable, which gives 64 completions. The five live status inputs are small enough to sweep through all 32 combinations. Each combination is read back and is then followed by a status write that must leave it unchanged.

// File: rtl/dsp_csr_pkg.sv
package dsp_csr_pkg;
  localparam int ADDR_W = 5;
  localparam int CTRL_W = 6;
  localparam int N_STICKY = 3;

  typedef enum logic [2:0] {
    IDX_STAT = 3'd0,
    IDX_CTRL = 3'd1,
    IDX_FILL = 3'd2,
    IDX_RESP = 3'd3,
    IDX_SEQ  = 3'd4
  } reg_idx_e;

  // control bit positions
  localparam int C_STOP  = 0;
  localparam int C_RST   = 1;
  localparam int C_SOE   = 2;
  localparam int C_SOET  = 3;
  localparam int C_GIE   = 4;
  localparam int C_SDESC = 5;

  // sticky flag slots, mapped to status bits 7..9
  localparam int F_ERR   = 0;
  localparam int F_EARLY = 1;
  localparam int F_IRQ   = 2;
  localparam int S_STICKY_LO = 7;
endpackage

// File: rtl/dsp_csr_ctrl.sv
module dsp_csr_ctrl
  import dsp_csr_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              resetting_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (wdata_i[C_RST]) begin
        cnt_q  <= CNT_W'(RST_CYCLES);
        ctrl_q <= '0;
      end else begin
        ctrl_q <= wdata_i & ~(CTRL_W'(1) << C_RST);
      end
    end
  end

  assign ctrl_o      = ctrl_q;
  assign resetting_o = (cnt_q != '0);
endmodule

// File: rtl/dsp_csr_flags.sv
module dsp_csr_flags
  import dsp_csr_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmpl_valid_i,
  input  logic                cmpl_done_irq_i,
  input  logic [ERR_W-1:0]    cmpl_err_i,
  input  logic [ERR_W-1:0]    cmpl_err_irq_i,
  input  logic                cmpl_early_i,
  input  logic                cmpl_early_irq_i,
  input  logic                soe_i,
  input  logic                soet_i,
  input  logic [N_STICKY-1:0] clr_i,
  output logic [N_STICKY-1:0] flags_o
);
  logic [N_STICKY-1:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[F_ERR]   = cmpl_valid_i && (|cmpl_err_i) && soe_i;
    set_v[F_EARLY] = cmpl_valid_i && cmpl_early_i && soet_i;
    set_v[F_IRQ]   = cmpl_valid_i && (cmpl_done_irq_i
                                      || (|(cmpl_err_i & cmpl_err_irq_i))
                                      || (cmpl_early_i && cmpl_early_irq_i));
  end

  for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) f_q <= 1'b0;
      else         f_q <= set_v[k] | (f_q & ~clr_i[k]);  // set wins over clear
    end
    assign flags_o[k] = f_q;
  end
endmodule

// File: rtl/dsp_csr_rmux.sv
module dsp_csr_rmux
  import dsp_csr_pkg::*;
#(
  parameter int LVL_W = 16
) (
  input  logic [2:0]       idx_i,
  input  logic [9:0]       status_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [LVL_W-1:0] wr_fill_i,
  input  logic [LVL_W-1:0] rd_fill_i,
  input  logic [LVL_W-1:0] resp_fill_i,
  input  logic [LVL_W-1:0] wr_seq_i,
  input  logic [LVL_W-1:0] rd_seq_i,
  output logic [31:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (reg_idx_e'(idx_i))
      IDX_STAT: rdata_o[9:0] = status_i;
      IDX_CTRL: rdata_o[CTRL_W-1:0] = ctrl_i;
      IDX_FILL: begin
        rdata_o[16 +: LVL_W] = wr_fill_i;
        rdata_o[0  +: LVL_W] = rd_fill_i;
      end
      IDX_RESP: rdata_o[0 +: LVL_W] = resp_fill_i;
      IDX_SEQ: begin
        rdata_o[16 +: LVL_W] = wr_seq_i;
        rdata_o[0  +: LVL_W] = rd_seq_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dsp_csr.sv
module dsp_csr
  import dsp_csr_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int LVL_W      = 16,
  parameter int ERR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              eng_busy_i,
  input  logic              dq_empty_i,
  input  logic              dq_full_i,
  input  logic              rq_empty_i,
  input  logic              rq_full_i,
  input  logic [LVL_W-1:0]  wr_fill_i,
  input  logic [LVL_W-1:0]  rd_fill_i,
  input  logic [LVL_W-1:0]  resp_fill_i,
  input  logic [LVL_W-1:0]  wr_seq_i,
  input  logic [LVL_W-1:0]  rd_seq_i,
  input  logic              cmpl_valid_i,
  input  logic              cmpl_done_irq_i,
  input  logic [ERR_W-1:0]  cmpl_err_i,
  input  logic [ERR_W-1:0]  cmpl_err_irq_i,
  input  logic              cmpl_early_i,
  input  logic              cmpl_early_irq_i,
  output logic              stop_o,
  output logic              reset_o,
  output logic              irq_o
);
  logic [2:0]          idx;
  logic                ctrl_we, stat_we, resetting;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [N_STICKY-1:0] clr, flags_q;
  logic [9:0]          status;
  logic                unused_bits;

  assign idx     = addr_i[4:2];
  assign ctrl_we = we_i && (reg_idx_e'(idx) == IDX_CTRL);
  assign stat_we = we_i && (reg_idx_e'(idx) == IDX_STAT);
  assign clr     = stat_we ? wdata_i[S_STICKY_LO +: N_STICKY] : '0;
  assign unused_bits = ^{wdata_i[31:CTRL_W], addr_i[1:0]};

  dsp_csr_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_we),
    .wdata_i     (wdata_i[CTRL_W-1:0]),
    .ctrl_o      (ctrl_q),
    .resetting_o (resetting)
  );

  dsp_csr_flags #(.ERR_W(ERR_W)) u_flags (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cmpl_valid_i     (cmpl_valid_i),
    .cmpl_done_irq_i  (cmpl_done_irq_i),
    .cmpl_err_i       (cmpl_err_i),
    .cmpl_err_irq_i   (cmpl_err_irq_i),
    .cmpl_early_i     (cmpl_early_i),
    .cmpl_early_irq_i (cmpl_early_irq_i),
    .soe_i            (ctrl_q[C_SOE]),
    .soet_i           (ctrl_q[C_SOET]),
    .clr_i            (clr),
    .flags_o          (flags_q)
  );

  assign stop_o  = ctrl_q[C_STOP] | ctrl_q[C_SDESC] | flags_q[F_ERR] | flags_q[F_EARLY];
  assign reset_o = resetting;
  assign irq_o   = flags_q[F_IRQ] & ctrl_q[C_GIE];

  assign status = {flags_q, resetting, stop_o & ~eng_busy_i,
                   rq_full_i, rq_empty_i, dq_full_i, dq_empty_i, eng_busy_i};

  dsp_csr_rmux #(.LVL_W(LVL_W)) u_rmux (
    .idx_i       (idx),
    .status_i    (status),
    .ctrl_i      (ctrl_q),
    .wr_fill_i   (wr_fill_i),
    .rd_fill_i   (rd_fill_i),
    .resp_fill_i (resp_fill_i),
    .wr_seq_i    (wr_seq_i),
    .rd_seq_i    (rd_seq_i),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/dsp_csr_chk.sv
module dsp_csr_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [4:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             cmpl_valid_i,
  input logic             cmpl_done_irq_i,
  input logic [ERR_W-1:0] cmpl_err_i,
  input logic [5:0]       ctrl_q,
  input logic [2:0]       flags_q,
  input logic             stop_o,
  input logic             reset_o,
  input logic             irq_o
);
  AST_RST_CTRL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> ctrl_q == 6'd0); // R5
  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_o) |-> $past(we_i && addr_i[4:2] == 3'd1 && wdata_i[1])); // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q[4]); // R7
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && cmpl_done_irq_i |=> flags_q[2]); // R6
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && (|cmpl_err_i) && ctrl_q[2] |=> stop_o); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[0] |-> stop_o); // R9
endmodule

bind dsp_csr dsp_csr_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .we_i            (we_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .cmpl_valid_i    (cmpl_valid_i),
  .cmpl_done_irq_i (cmpl_done_irq_i),
  .cmpl_err_i      (cmpl_err_i),
  .ctrl_q          (ctrl_q),
  .flags_q         (flags_q),
  .stop_o          (stop_o),
  .reset_o         (reset_o),
  .irq_o           (irq_o)
);

// File: tb/sim_dsp_csr.sv
`timescale 1ns/1ps
module sim_dsp_csr;
  localparam int RST_N = 5;
  localparam logic [4:0] A_STAT = 5'h00, A_CTRL = 5'h04, A_FILL = 5'h08,
                         A_RESP = 5'h0C, A_SEQ = 5'h10;

  logic clk_i = 0, rst_ni = 0, we_i = 0;
  logic [4:0]  addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic eng_busy_i = 0, dq_empty_i = 0, dq_full_i = 0, rq_empty_i = 0, rq_full_i = 0;
  logic [15:0] wr_fill_i = 0, rd_fill_i = 0, resp_fill_i = 0, wr_seq_i = 0, rd_seq_i = 0;
  logic cmpl_valid_i = 0, cmpl_done_irq_i = 0, cmpl_early_i = 0, cmpl_early_irq_i = 0;
  logic [7:0] cmpl_err_i = 0, cmpl_err_irq_i = 0;
  logic stop_o, reset_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  dsp_csr #(.RST_CYCLES(RST_N)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 0; wdata_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse(input logic dn, input logic [7:0] e, input logic [7:0] een,
                       input logic er, input logic eren);
    cmpl_valid_i = 1; cmpl_done_irq_i = dn; cmpl_err_i = e; cmpl_err_irq_i = een;
    cmpl_early_i = er; cmpl_early_irq_i = eren;
    @(negedge clk_i);
    cmpl_valid_i = 0; cmpl_done_irq_i = 0; cmpl_err_i = 0; cmpl_err_irq_i = 0;
    cmpl_early_i = 0; cmpl_early_irq_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 outs", {29'd0, irq_o, stop_o, reset_o}, 0);

    // R3 live bits sweep, status writes ignored for bits 0..6
    for (int i = 0; i < 32; i++) begin
      {rq_full_i, rq_empty_i, dq_full_i, dq_empty_i, eng_busy_i} = 5'(i);
      rd(A_STAT, d); chk("R3 live", d, 32'(i));
      wr(A_STAT, 32'h7F);
      rd(A_STAT, d); chk("R3 write ignored", d, 32'(i));
    end
    {rq_full_i, rq_empty_i, dq_full_i, dq_empty_i, eng_busy_i} = 0;

    // R2 read map
    for (int i = 0; i < 4; i++) begin
      wr_fill_i = 16'h1234 + 16'(i * 16'h1111); rd_fill_i = ~wr_fill_i;
      resp_fill_i = 16'h8001 >> i; wr_seq_i = 16'hA5A5 ^ 16'(i); rd_seq_i = 16'(i * 7);
      rd(A_FILL, d); chk("R2 fill", d, {wr_fill_i, rd_fill_i});
      rd(A_RESP, d); chk("R2 resp", d, {16'd0, resp_fill_i});
      rd(A_SEQ, d);  chk("R2 seq", d, {wr_seq_i, rd_seq_i});
    end
    for (int a = 5; a < 8; a++) begin
      rd(5'(a << 2), d); chk("R2 unmapped", d, 0);
    end
    wr(A_FILL, 32'hFFFF_FFFF); wr(A_SEQ, 32'h3F);
    rd(A_CTRL, d); chk("R2 write ignored", d, 0);

    // R4 control storage and stop
    wr(A_CTRL, 32'h3D); rd(A_CTRL, d); chk("R4 ctrl rb", d, 32'h3D);
    chk("R4 stop", stop_o, 1);
    wr(A_CTRL, 32'h1C); chk("R4 stop off", stop_o, 0);
    wr(A_CTRL, 32'h20); chk("R4 stop desc", stop_o, 1);
    wr(A_CTRL, 32'h01); chk("R4 stop bit", stop_o, 1);

    // R11 stopped bit
    eng_busy_i = 1; rd(A_STAT, d); chk("R11 busy", d[5], 0);
    eng_busy_i = 0; rd(A_STAT, d); chk("R11 idle", d[5], 1);
    wr(A_CTRL, 32'h10); rd(A_STAT, d); chk("R11 clear", d[5], 0);

    // R6 error/enable pairing sweep, R7 output, R8 clear
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        pulse(0, 8'(1 << i), 8'(1 << j), 0, 0);
        rd(A_STAT, d); chk("R6 err irq", d[9], (i == j));
        chk("R7 irq_o", irq_o, (i == j));
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); chk("R8 clear", d[9], 0);
      end
    pulse(1, 0, 0, 0, 0); rd(A_STAT, d); chk("R6 done", d[9], 1); wr(A_STAT, 32'h200);
    pulse(0, 0, 0, 1, 1); rd(A_STAT, d); chk("R6 early en", d[9], 1); wr(A_STAT, 32'h200);
    pulse(0, 0, 0, 1, 0); rd(A_STAT, d); chk("R6 early no en", d[9], 0);
    pulse(0, 0, 0, 0, 1); rd(A_STAT, d); chk("R6 en only", d[9], 0);

    // R7 gating
    wr(A_CTRL, 32'h00);
    pulse(1, 0, 0, 0, 0); chk("R7 gated", irq_o, 0);
    rd(A_STAT, d); chk("R7 pending", d[9], 1);
    wr(A_CTRL, 32'h10); chk("R7 enabled", irq_o, 1);
    // R8 zero bits keep, same-cycle set wins
    wr(A_STAT, 32'h180); rd(A_STAT, d); chk("R8 keep", d[9], 1);
    wr(A_STAT, 32'h200); chk("R8 cleared", irq_o, 0);
    we_i = 1; addr_i = A_STAT; wdata_i = 32'h200;
    pulse(1, 0, 0, 0, 0);
    we_i = 0; wdata_i = 0;
    rd(A_STAT, d); chk("R8 set wins", d[9], 1);
    wr(A_STAT, 32'h200);

    // R9 stop on error
    wr(A_CTRL, 32'h10);
    pulse(0, 8'h04, 0, 0, 0); rd(A_STAT, d); chk("R9 soe off", d[9:5], 0);
    wr(A_CTRL, 32'h14);
    pulse(0, 8'h04, 0, 0, 0); rd(A_STAT, d); chk("R9 soe bits", d[9:5], 5'b00101);
    chk("R9 stop", stop_o, 1);
    wr(A_STAT, 32'h80); rd(A_STAT, d); chk("R9 released", d[9:5], 0);
    chk("R9 stop off", stop_o, 0);

    // R10 stop on early end
    wr(A_CTRL, 32'h18);
    pulse(0, 0, 0, 1, 0); rd(A_STAT, d); chk("R10 bits", d[9:5], 5'b01001);
    chk("R10 stop", stop_o, 1);
    wr(A_STAT, 32'h100); chk("R10 stop off", stop_o, 0);

    // R5 soft reset
    wr(A_CTRL, 32'h1C);
    wr(A_CTRL, 32'h1E);
    n = 0;
    while (reset_o && n < 50) begin
      if (n == 0) begin
        rd(A_STAT, d); chk("R5 flag", d[6], 1);
        rd(A_CTRL, d); chk("R5 ctrl zero", d, 0);
      end
      if (n == 1) begin we_i = 1; addr_i = A_CTRL; wdata_i = 32'h10; end
      if (n == 2) begin we_i = 0; wdata_i = 0; end
      n++;
      @(negedge clk_i);
    end
    we_i = 0;
    chk("R5 length", n, RST_N);
    rd(A_CTRL, d); chk("R5 write ignored", d, 0);
    rd(A_STAT, d); chk("R5 flag off", d[6], 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule